// File: doc/BRIEF.md
# Prioritised Interrupt Acceptance Controller

This block gathers every interrupt request aimed at a processor core and decides which single request the core takes next. It has three kinds of source. The first is a non-maskable input that is detected on an edge. The second is six level-sensitive request lines, each with its own programmable priority; the lowest four can instead be read together as one 4-bit encoded priority. The third is a parameterised set of peripheral requests with programmable priorities. It finds the best pending request and compares it with the core's current 4-bit mask level and its block flag. It then offers the winner to the core on a valid/ready handshake.

The offer carries a source code, the accepted priority and the mask level that the core should load into its status register. Once the offer is raised it stays fixed until the core sets `acc_ready`, so the core can apply back-pressure for as long as it needs. When a handshake completes, `acc_valid` drops for at least one cycle before the next offer. Level sources are not latched: a line that drops before it is offered is never seen. The non-maskable edge is latched, and that latch is cleared only when the core takes that offer. An active-low pending pin follows the offer, and a wake output pulses when a non-maskable request is taken while the sleep/standby status input is high.

Source codes: 0 is the non-maskable input. 1 to 6 are request lines 0 to 5. 7 is the encoded level. 8 and up are the peripherals, in index order. The control register is written as a whole 4-bit word: bit 0 selects the rising edge (0 selects falling), bit 1 is the block-mask bit, bit 2 is the mask-accept bit and bit 3 selects encoded mode.

Top module: `irq_accept_ctl`

## Requirements
- R1: A source whose priority is 0 is never offered, whatever the mask level. A programmed priority above 16 is treated as 16.
- R2: A maskable source is offered only when `core_bl` is 0 and its priority is strictly greater than `core_mask`.
- R3: Among eligible maskable sources the highest priority wins, and on equal priority the lower source code wins.
- R4: The non-maskable request is offered with code 0 and priority 16, ahead of any maskable source.
- R5: A latched non-maskable request may be offered only when the block-mask bit is 1, or when the effective block flag is 0 and the mask-accept bit is 0. Otherwise it stays latched.
- R6: With `core_bl`=1 and the block-mask bit set to 1, the non-maskable request is the only source ever offered.
- R7: Control bit 0 selects the edge: 1 latches on a rising edge and 0 on a falling edge. The opposite edge latches nothing.
- R8: An edge latches only if the new level is held for at least 2 clock cycles. A 1-cycle pulse latches nothing.
- R9: While `sleep_in`=1 the block flag is ignored for the non-maskable request. Offering that request while asleep raises `wake_o` for exactly the cycle in which the offer first appears.
- R10: For the non-maskable offer, `acc_mask` equals the `core_mask` of the cycle before the offer. For a maskable offer it equals the priority, saturated at 15.
- R11: With bit 3 set, lines 3..0 no longer act as individual requests. Their value, read as an unsigned number, is one request with code 7 and that value as its priority, where 0 means no request.
- R12: An offer holds `acc_src`, `acc_prio` and `acc_mask` stable until `acc_ready`. After the handshake, `acc_valid` is 0 in the next cycle, and a taken non-maskable request does not return.
- R13: `irq_pend_n` is 0 exactly while an offer is outstanding.
- R14: A register write with `cfg_we` stores `cfg_wdata`, and `cfg_rdata` returns it from the next cycle on. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control word to write |
| cfg_rdata | output | 4 | Current control word |
| nmi_pin | input | 1 | Non-maskable request input |
| ext_pin | input | NEXT | Level request lines, shared with the encoded level |
| ext_prio | input | NEXT*5 | Priority of each request line, 5 bits each |
| per_req | input | NPER | Peripheral request levels |
| per_prio | input | NPER*5 | Priority of each peripheral, 5 bits each |
| core_bl | input | 1 | Core block flag |
| core_mask | input | 4 | Core interrupt mask level |
| sleep_in | input | 1 | Sleep or standby status |
| acc_valid | output | 1 | Offer valid |
| acc_ready | input | 1 | Core takes the offer |
| acc_src | output | SRC_W | Source code of the offer |
| acc_prio | output | 5 | Priority of the offer |
| acc_mask | output | 4 | Mask level for the core to load |
| wake_o | output | 1 | Wake pulse on a non-maskable offer during sleep |
| irq_pend_n | output | 1 | Active-low pending pin |

## Verification
The hardest case to reach from the ports is a non-maskable request that is latched while acceptance is refused and is released later. This happens either through the sleep override, which must also pulse `wake_o`, or through a change of the block-mask bit. The latch is invisible until that release. The bench therefore drives directed sequences that first hold an edge off under each refusing combination and then lift one condition at a known negedge, so that the offer and the wake pulse are expected in one exact cycle. The 1-cycle versus 2-cycle pulse width boundary is driven directly on the pin. Random trials cover arbitration, ties, clamping and encoded mode.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;
  localparam int PRIO_W = 5;
  localparam int MASK_W = 4;
  localparam int ENC_W  = 4;
  localparam logic [PRIO_W-1:0] PRIO_TOP = 5'd16;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [MASK_W-1:0] mask_t;

  typedef struct packed {
    logic enc_mode;
    logic mask_accept;
    logic blk_mask;
    logic nmi_rise;
  } ctl_t;

  function automatic prio_t prio_clamp(input prio_t p);
    return (p > PRIO_TOP) ? PRIO_TOP : p;
  endfunction

  function automatic mask_t prio_to_mask(input prio_t p);
    return (p > 5'd15) ? 4'hF : p[MASK_W-1:0];
  endfunction
endpackage

// File: rtl/irq_nmi_filter.sv
module irq_nmi_filter #(
  parameter int MIN_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  input  logic clear,
  output logic pend
);
  logic [MIN_W-1:0] hist;
  logic             lvl;
  logic             all_hi, all_lo, edge_ok;

  assign all_hi  = &hist;
  assign all_lo  = ~|hist;
  assign edge_ok = (all_hi && !lvl && rise_sel) || (all_lo && lvl && !rise_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      lvl  <= 1'b0;
      pend <= 1'b0;
    end else begin
      hist <= {hist[MIN_W-2:0], pin};
      if (all_hi)      lvl <= 1'b1;
      else if (all_lo) lvl <= 1'b0;
      if (edge_ok)     pend <= 1'b1;
      else if (clear)  pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cand_build.sv
module irq_cand_build
  import irq_acc_pkg::*;
#(
  parameter int NEXT  = 6,
  parameter int NPER  = 8,
  parameter int NCAND = NEXT + 1 + NPER
) (
  input  logic                    enc_mode,
  input  logic [NEXT-1:0]         ext_pin,
  input  logic [NEXT*PRIO_W-1:0]  ext_prio,
  input  logic [NPER-1:0]         per_req,
  input  logic [NPER*PRIO_W-1:0]  per_prio,
  output logic [NCAND-1:0]        cand_req,
  output logic [NCAND*PRIO_W-1:0] cand_prio
);
  for (genvar i = 0; i < NEXT; i++) begin : g_ext
    if (i < ENC_W) begin : g_shared
      assign cand_req[i] = ext_pin[i] & ~enc_mode;
    end else begin : g_plain
      assign cand_req[i] = ext_pin[i];
    end
    assign cand_prio[i*PRIO_W +: PRIO_W] = prio_clamp(ext_prio[i*PRIO_W +: PRIO_W]);
  end

  assign cand_req[NEXT] = enc_mode & (|ext_pin[ENC_W-1:0]);
  assign cand_prio[NEXT*PRIO_W +: PRIO_W] = {1'b0, ext_pin[ENC_W-1:0]};

  for (genvar j = 0; j < NPER; j++) begin : g_per
    assign cand_req[NEXT+1+j] = per_req[j];
    assign cand_prio[(NEXT+1+j)*PRIO_W +: PRIO_W] = prio_clamp(per_prio[j*PRIO_W +: PRIO_W]);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_acc_pkg::*;
#(
  parameter int N     = 15,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]        req,
  input  logic [N*PRIO_W-1:0] prio_flat,
  input  mask_t               thresh,
  input  logic                enable,
  output logic                hit,
  output logic [IDX_W-1:0]    idx,
  output prio_t               prio
);
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    prio = '0;
    for (int i = 0; i < N; i++) begin
      // strict compare against the running best keeps the lower index on ties
      if (enable && req[i] &&
          prio_flat[i*PRIO_W +: PRIO_W] > {1'b0, thresh} &&
          prio_flat[i*PRIO_W +: PRIO_W] > prio) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_accept_ctl.sv
module irq_accept_ctl
  import irq_acc_pkg::*;
#(
  parameter int NEXT  = 6,
  parameter int NPER  = 8,
  parameter int MIN_W = 2,
  parameter int SRC_W = $clog2(NEXT + NPER + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [3:0]             cfg_wdata,
  output logic [3:0]             cfg_rdata,
  input  logic                   nmi_pin,
  input  logic [NEXT-1:0]        ext_pin,
  input  logic [NEXT*5-1:0]      ext_prio,
  input  logic [NPER-1:0]        per_req,
  input  logic [NPER*5-1:0]      per_prio,
  input  logic                   core_bl,
  input  logic [3:0]             core_mask,
  input  logic                   sleep_in,
  output logic                   acc_valid,
  input  logic                   acc_ready,
  output logic [SRC_W-1:0]       acc_src,
  output logic [4:0]             acc_prio,
  output logic [3:0]             acc_mask,
  output logic                   wake_o,
  output logic                   irq_pend_n
);
  localparam int NCAND = NEXT + 1 + NPER;
  localparam int IDX_W = $clog2(NCAND);

  ctl_t                    ctl;
  logic                    nmi_pend, nmi_clear, nmi_ok, nmi_take, bl_eff;
  logic [NCAND-1:0]        cand_req;
  logic [NCAND*PRIO_W-1:0] cand_prio;
  logic                    pick_hit;
  logic [IDX_W-1:0]        pick_idx;
  prio_t                   pick_prio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= '0;
    else if (cfg_we) ctl <= ctl_t'(cfg_wdata);
  end
  assign cfg_rdata = ctl;

  assign nmi_clear = acc_valid & acc_ready & (acc_src == '0);

  irq_nmi_filter #(.MIN_W(MIN_W)) u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (nmi_pin),
    .rise_sel (ctl.nmi_rise),
    .clear    (nmi_clear),
    .pend     (nmi_pend)
  );

  irq_cand_build #(.NEXT(NEXT), .NPER(NPER), .NCAND(NCAND)) u_cand (
    .enc_mode  (ctl.enc_mode),
    .ext_pin   (ext_pin),
    .ext_prio  (ext_prio),
    .per_req   (per_req),
    .per_prio  (per_prio),
    .cand_req  (cand_req),
    .cand_prio (cand_prio)
  );

  irq_prio_pick #(.N(NCAND), .IDX_W(IDX_W)) u_pick (
    .req       (cand_req),
    .prio_flat (cand_prio),
    .thresh    (core_mask),
    .enable    (~core_bl),
    .hit       (pick_hit),
    .idx       (pick_idx),
    .prio      (pick_prio)
  );

  assign bl_eff   = core_bl & ~sleep_in;
  assign nmi_ok   = ctl.blk_mask | (~bl_eff & ~ctl.mask_accept);
  assign nmi_take = nmi_pend & nmi_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid  <= 1'b0;
      acc_src    <= '0;
      acc_prio   <= '0;
      acc_mask   <= '0;
      wake_o     <= 1'b0;
      irq_pend_n <= 1'b1;
    end else begin
      wake_o <= 1'b0;
      if (acc_valid) begin
        if (acc_ready) begin
          acc_valid  <= 1'b0;
          irq_pend_n <= 1'b1;
        end
      end else if (nmi_take) begin
        acc_valid  <= 1'b1;
        irq_pend_n <= 1'b0;
        acc_src    <= '0;
        acc_prio   <= PRIO_TOP;
        acc_mask   <= core_mask;
        wake_o     <= sleep_in;
      end else if (pick_hit) begin
        acc_valid  <= 1'b1;
        irq_pend_n <= 1'b0;
        acc_src    <= SRC_W'(pick_idx) + SRC_W'(1);
        acc_prio   <= pick_prio;
        acc_mask   <= prio_to_mask(pick_prio);
      end
    end
  end
endmodule

// File: rtl/irq_accept_ctl_chk.sv
module irq_accept_ctl_chk #(
  parameter int SRC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic [SRC_W-1:0] acc_src,
  input logic [4:0]       acc_prio,
  input logic [3:0]       acc_mask,
  input logic             core_bl,
  input logic [3:0]       core_mask,
  input logic             wake_o,
  input logic             irq_pend_n
);
  assert_prio_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> acc_prio != 5'd0);

  assert_above_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(acc_valid) && acc_src != '0) |-> (acc_prio > {1'b0, $past(core_mask)} && !$past(core_bl)));

  assert_nmi_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_src == '0) |-> acc_prio == 5'd16);

  assert_wake_nmi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (acc_valid && acc_src == '0 && $rose(acc_valid)));

  assert_nmi_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(acc_valid) && acc_src == '0) |-> acc_mask == $past(core_mask));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_src) && $stable(acc_prio) && $stable(acc_mask)));

  assert_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> !acc_valid);

  assert_pin_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend_n == !acc_valid);
endmodule

bind irq_accept_ctl irq_accept_ctl_chk #(.SRC_W(SRC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_src    (acc_src),
  .acc_prio   (acc_prio),
  .acc_mask   (acc_mask),
  .core_bl    (core_bl),
  .core_mask  (core_mask),
  .wake_o     (wake_o),
  .irq_pend_n (irq_pend_n)
);

// File: tb/irq_accept_ctl_bench.sv
`timescale 1ns/1ps
module irq_accept_ctl_bench;
  localparam int NEXT  = 6;
  localparam int NPER  = 8;
  localparam int SRC_W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             cfg_we;
  logic [3:0]       cfg_wdata, cfg_rdata;
  logic             nmi_pin;
  logic [NEXT-1:0]  ext_pin;
  logic [NEXT*5-1:0] ext_prio;
  logic [NPER-1:0]  per_req;
  logic [NPER*5-1:0] per_prio;
  logic             core_bl, sleep_in, acc_ready;
  logic [3:0]       core_mask;
  logic             acc_valid, wake_o, irq_pend_n;
  logic [SRC_W-1:0] acc_src;
  logic [4:0]       acc_prio;
  logic [3:0]       acc_mask;

  logic [4:0] ep [NEXT];
  logic [4:0] pp [NPER];
  logic [3:0] cur_cfg;

  always_comb begin
    for (int i = 0; i < NEXT; i++) ext_prio[i*5 +: 5] = ep[i];
    for (int j = 0; j < NPER; j++) per_prio[j*5 +: 5] = pp[j];
  end

  irq_accept_ctl #(.NEXT(NEXT), .NPER(NPER)) u_irq_accept_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .nmi_pin(nmi_pin), .ext_pin(ext_pin), .ext_prio(ext_prio), .per_req(per_req),
    .per_prio(per_prio), .core_bl(core_bl), .core_mask(core_mask), .sleep_in(sleep_in),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_src(acc_src), .acc_prio(acc_prio),
    .acc_mask(acc_mask), .wake_o(wake_o), .irq_pend_n(irq_pend_n)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] clampf(input logic [4:0] p);
    return (p > 5'd16) ? 5'd16 : p;
  endfunction

  // reference: {hit, code[3:0], prio[4:0]}
  function automatic logic [9:0] ref_pick();
    logic [4:0] bp = 0;
    logic [3:0] bc = 0;
    logic [4:0] p;
    bit enc = cur_cfg[3];
    if (core_bl) return '0;
    for (int i = 0; i < NEXT; i++) begin
      p = clampf(ep[i]);
      if (ext_pin[i] && !(enc && i < 4) && p > {1'b0, core_mask} && p > bp) begin
        bp = p; bc = 4'(i + 1);
      end
    end
    p = {1'b0, ext_pin[3:0]};
    if (enc && p != 0 && p > {1'b0, core_mask} && p > bp) begin
      bp = p; bc = 4'(NEXT + 1);
    end
    for (int j = 0; j < NPER; j++) begin
      p = clampf(pp[j]);
      if (per_req[j] && p > {1'b0, core_mask} && p > bp) begin
        bp = p; bc = 4'(NEXT + 2 + j);
      end
    end
    return {(bp != 0), bc, bp};
  endfunction

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic write_cfg(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v; cur_cfg = v;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic clear_reqs();
    ext_pin = '0; per_req = '0;
  endtask

  task automatic ack();
    acc_ready = 1'b1;
    step(1);
    acc_ready = 1'b0;
  endtask

  task automatic pulse_nmi(input logic active, input int len);
    nmi_pin = active; step(len); nmi_pin = ~active;
  endtask

  task automatic wait_valid(input int maxc, output bit got);
    got = 0;
    for (int k = 0; k < maxc; k++) begin
      if (acc_valid) begin got = 1; break; end
      step(1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R12 watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit got;
    logic [9:0] e;
    logic [3:0] em;
    void'($urandom(32'd4711));
    rst_n = 0; cfg_we = 0; cfg_wdata = 0; cur_cfg = 0; nmi_pin = 0;
    ext_pin = 0; per_req = 0; core_bl = 0; core_mask = 0; sleep_in = 0; acc_ready = 0;
    for (int i = 0; i < NEXT; i++) ep[i] = 0;
    for (int j = 0; j < NPER; j++) pp[j] = 0;
    step(3);
    rst_n = 1;
    @(negedge clk);
    chk(acc_valid == 0, "R12 reset valid", acc_valid, 0);
    chk(irq_pend_n == 1, "R13 reset pin", irq_pend_n, 1);
    chk(cfg_rdata == 0, "R14 reset cfg", cfg_rdata, 0);
    chk(wake_o == 0, "R9 reset wake", wake_o, 0);

    write_cfg(4'b1011);
    chk(cfg_rdata == 4'b1011, "R14 readback", cfg_rdata, 11);
    write_cfg(4'b0001);
    chk(cfg_rdata == 4'b0001, "R14 readback", cfg_rdata, 1);

    // directed: tie on priority -> lower code (R3), priority 0 ignored (R1)
    ep[1] = 7; ep[4] = 7; pp[0] = 0; per_req[0] = 1; ext_pin = 6'b010010; core_mask = 2;
    step(1);
    chk(acc_valid && acc_src == 2, "R3 tie lower code", acc_src, 2);
    chk(irq_pend_n == 0, "R13 pin low", irq_pend_n, 0);
    ext_pin = 0; per_req = 0; ep[5] = 9; ext_pin[5] = 1;
    step(2);
    chk(acc_src == 2 && acc_prio == 7, "R12 hold", acc_src, 2);
    clear_reqs(); ack();
    chk(acc_valid == 0, "R12 drop after ack", acc_valid, 0);
    step(1);
    per_req[0] = 1; core_mask = 0;
    step(3);
    chk(acc_valid == 0, "R1 prio0 ignored", acc_valid, 0);
    per_req = 0;

    // clamp above 16 (R1) and mask saturation (R10)
    pp[2] = 5'd25; per_req[2] = 1; core_mask = 15;
    step(1);
    chk(acc_valid && acc_prio == 16 && acc_src == 10, "R1 clamp", acc_prio, 16);
    chk(acc_mask == 15, "R10 mask saturate", acc_mask, 15);
    clear_reqs(); ack(); step(1);

    // encoded mode (R11)
    write_cfg(4'b1001);
    for (int i = 0; i < 4; i++) ep[i] = 16;
    ext_pin = 6'b000101; core_mask = 3;
    step(1);
    chk(acc_valid && acc_src == 7 && acc_prio == 5, "R11 encoded", acc_src, 7);
    chk(acc_mask == 5, "R10 maskable mask", acc_mask, 5);
    clear_reqs(); ack(); step(1);
    ext_pin = 6'b000010;
    step(3);
    chk(acc_valid == 0, "R2 encoded below mask", acc_valid, 0);
    clear_reqs();
    write_cfg(4'b0001);

    // random arbitration trials (R1 R2 R3 R10 R11 R12 R13)
    for (int t = 0; t < 400; t++) begin
      write_cfg({1'($urandom_range(0, 1)), 3'b001});
      for (int i = 0; i < NEXT; i++) ep[i] = 5'($urandom_range(0, 20));
      for (int j = 0; j < NPER; j++) pp[j] = 5'($urandom_range(0, 20));
      ext_pin   = 6'($urandom);
      per_req   = 8'($urandom);
      core_mask = 4'($urandom_range(0, 15));
      core_bl   = ($urandom_range(0, 7) == 0);
      e = ref_pick();
      step(1);
      chk(acc_valid == e[9], "R2 random offer", acc_valid, e[9]);
      if (e[9]) begin
        em = (e[4:0] > 15) ? 4'hF : e[3:0];
        chk(acc_src == e[8:5] && acc_prio == e[4:0], "R3 random winner",
            {acc_src, acc_prio}, {e[8:5], e[4:0]});
        chk(acc_mask == em, "R10 random mask", acc_mask, em);
        chk(irq_pend_n == 0, "R13 random pin", irq_pend_n, 0);
        clear_reqs(); ack();
        chk(acc_valid == 0, "R12 random drop", acc_valid, 0);
      end else begin
        clear_reqs();
      end
      core_bl = 0;
      step(1);
    end

    // NMI pulse width (R8) and priority over maskable (R4, R10)
    write_cfg(4'b0001); core_mask = 9; ep[5] = 16; ext_pin[5] = 0;
    pulse_nmi(1'b1, 1);
    step(6);
    chk(acc_valid == 0, "R8 short pulse ignored", acc_valid, 0);
    core_bl = 1;
    pulse_nmi(1'b1, 2);
    ext_pin[5] = 1;
    step(1);
    core_bl = 0;
    wait_valid(8, got);
    chk(got && acc_src == 0 && acc_prio == 16, "R4 nmi wins", acc_src, 0);
    chk(acc_mask == 9, "R10 nmi keeps mask", acc_mask, 9);
    ack();
    step(1);
    chk(acc_valid && acc_src == 6, "R12 nmi not repeated", acc_src, 6);
    clear_reqs(); ack(); step(2);

    // blocked then released by sleep (R5, R9)
    core_bl = 1;
    pulse_nmi(1'b1, 3);
    step(6);
    chk(acc_valid == 0, "R5 blocked by bl", acc_valid, 0);
    sleep_in = 1;
    step(1);
    chk(acc_valid && acc_src == 0, "R9 sleep override", acc_src, 0);
    chk(wake_o == 1, "R9 wake pulse", wake_o, 1);
    step(1);
    chk(wake_o == 0, "R9 wake one cycle", wake_o, 0);
    ack(); sleep_in = 0; core_bl = 0; step(2);

    // mask-accept holds off; block-mask releases; only NMI while bl (R5, R6)
    write_cfg(4'b0101);
    pulse_nmi(1'b1, 3);
    step(6);
    chk(acc_valid == 0, "R5 mask-accept holds", acc_valid, 0);
    core_bl = 1; ext_pin[5] = 1; core_mask = 0;
    write_cfg(4'b0111);
    wait_valid(4, got);
    chk(got && acc_src == 0, "R6 nmi under block", acc_src, 0);
    ack();
    step(5);
    chk(acc_valid == 0, "R6 maskable held off", acc_valid, 0);
    core_bl = 0;
    step(1);
    chk(acc_valid && acc_src == 6, "R2 released", acc_src, 6);
    clear_reqs(); ack(); step(2);

    // falling edge select (R7)
    write_cfg(4'b0000);
    nmi_pin = 1;
    step(6);
    chk(acc_valid == 0, "R7 rising ignored", acc_valid, 0);
    nmi_pin = 0;
    wait_valid(6, got);
    chk(got && acc_src == 0, "R7 falling latched", acc_src, 0);
    ack(); step(2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule